// File: doc/BRIEF.md
# Split-Access Wide Register Bank

This block is a small bank of 64-bit registers behind a 32-bit register port. Each wide register occupies two consecutive word addresses. The even word holds bits 63:32 and the odd word holds bits 31:0. A write to the even word only loads a shared staging word. The write to the odd word commits the staged upper half and the new lower half together in one cycle. This lets a 32-bit master update a 64-bit value without the register ever showing a mixed state.

The bank contains seven 64-bit performance counters and one configuration register. Three of the counters count events and four accumulate byte counts. Each counter is driven by its own strobe input. Reading the even word of a counter also latches the counter's live low word into a shared snapshot register. The odd-word read that follows returns that snapshot, so the two halves always belong to one sample.

The configuration register holds a watchdog enable, a watchdog force-fail and a DMA reset, all driven out on ports. It also has a self-clearing software-reset bit. Writing 1 to that bit raises a one-cycle reset pulse, and the pulse clears every counter and every configuration field.

Top module: `wide_reg_bank`

## Requirements
- R1: The word address splits into a register index (req_addr[4:1]) and a half select (req_addr[0]: 0 means bits 63:32, 1 means bits 31:0). Index 0 is the configuration register. Indices 1 to 7 are the counters, in this order: dequeued requests, outbound encrypt requests, inbound decrypt requests, outbound bytes encrypted, outbound bytes protected, inbound bytes decrypted, inbound bytes validated.
- R2: A write to an even word loads only the staging word. No register changes.
- R3: A write to an odd word of a mapped register commits {staging word, written word} to that register at the next clock edge. The staging word keeps its value after the commit. If a counter strobe arrives in the same cycle, the commit wins.
- R4: The staging word resets to zero. An odd-word write with no preceding even-word write uses whatever the staging word holds.
- R5: Reading a counter's even word returns the live bits 63:32 and latches the live bits 31:0. Any later read of a counter's odd word returns the latched value, even if the counter has moved since.
- R6: Counters 1 to 3 add 1 per strobe. Counters 4 to 7 add their 16-bit byte input per strobe (counter 4 uses evt_bytes[15:0], and so on upward). All counters wrap modulo 2^64.
- R7: The configuration low word carries bit 30 = watchdog enable, bit 29 = watchdog force-fail and bit 28 = DMA reset. These bits appear on wd_enable, wd_force_fail and dma_reset and read back live. All other configuration bits, including bit 31 and the whole upper word, read as 0.
- R8: Committing a configuration write with bit 31 set drives sw_rst high for exactly the one cycle after the commit edge.
- R9: While sw_rst is high, all counters and configuration fields are cleared at that edge, and any odd-word commit in that cycle is dropped.
- R10: Indices 8 to 15 read as zero, and writes to them change nothing except the staging word (even word only).
- R11: A read request produces rsp_valid with rsp_data one cycle later. A write produces no response.
- R12: After a synchronous reset, all registers, the staging word, the snapshot and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word address: index and half select |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| evt_strobe | input | 7 | One strobe per counter |
| evt_bytes | input | 64 | Byte increments for the four byte counters, 16 bits each |
| sw_rst | output | 1 | One-cycle software reset pulse |
| wd_enable | output | 1 | Watchdog enable field |
| wd_force_fail | output | 1 | Watchdog force-fail field |
| dma_reset | output | 1 | DMA reset field |

## Verification
A corrupted staging word is not visible until the next odd-word commit. It then shows up as a wrong upper half on the following even-word read. A stale or mis-latched snapshot appears only on an odd-word counter read, so the bench reads both halves of every counter while the strobes keep running. Counter and configuration errors show on the very next read response or on the field outputs one cycle after the faulty edge. A pulse that is too long or missing shows directly on sw_rst and on the counters reading zero.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
    localparam int WORD_W = 32;
    localparam int WIDE_W = 64;

    localparam int CFG_SWRST_BIT  = 31;
    localparam int CFG_WDEN_BIT   = 30;
    localparam int CFG_WDFAIL_BIT = 29;
    localparam int CFG_DMARST_BIT = 28;

    typedef enum logic {
        HALF_HI = 1'b0,
        HALF_LO = 1'b1
    } half_e;

    typedef struct packed {
        logic wd_en;
        logic wd_fail;
        logic dma_rst;
    } cfg_t;

    function automatic logic [WIDE_W-1:0] cfg_to_wide(input cfg_t c);
        logic [WIDE_W-1:0] w;
        w = '0;
        w[CFG_WDEN_BIT]   = c.wd_en;
        w[CFG_WDFAIL_BIT] = c.wd_fail;
        w[CFG_DMARST_BIT] = c.dma_rst;
        return w;
    endfunction
endpackage

// File: rtl/wrb_counter.sv
module wrb_counter #(
    parameter int CNT_W = 64,
    parameter int INC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc_val,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc_en) begin
            cnt <= cnt + CNT_W'(inc_val);
        end
    end

    // R9: a clear leaves the counter at zero
    assert_clr_zero_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
    // R6: with no strobe, load or clear the count holds
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && !inc_en) |=> $stable(cnt));
endmodule

// File: rtl/wrb_stage_snap.sv
module wrb_stage_snap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_stage,
    input  logic [W-1:0] stage_in,
    input  logic         cap_snap,
    input  logic [W-1:0] snap_in,
    output logic [W-1:0] stage_q,
    output logic [W-1:0] snap_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            snap_q  <= '0;
        end else begin
            if (ld_stage) stage_q <= stage_in;
            if (cap_snap) snap_q  <= snap_in;
        end
    end

    // R3: staging word survives commits and any access other than an even-word write
    assert_stage_keep_R3: assert property (@(posedge clk) disable iff (rst)
        !ld_stage |=> $stable(stage_q));
    // R5: latched low word holds until the next even-word counter read
    assert_snap_keep_R5: assert property (@(posedge clk) disable iff (rst)
        !cap_snap |=> $stable(snap_q));
endmodule

// File: rtl/wrb_cfg.sv
module wrb_cfg
    import wrb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       commit,
    input  logic [3:0] wtop,
    output cfg_t       cfg,
    output logic       pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= commit && wtop[3] && !pulse;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pulse) begin
            cfg <= '0;
        end else if (commit) begin
            cfg <= cfg_t'(wtop[2:0]);
        end
    end

    // R8: the reset pulse never lasts beyond one cycle
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
    // R9: the pulse leaves all configuration fields cleared
    assert_pulse_clears_cfg_R9: assert property (@(posedge clk) disable iff (rst)
        pulse |=> cfg == '0);
endmodule

// File: rtl/wide_reg_bank.sv
module wide_reg_bank
    import wrb_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int NUM_EVT  = 3,
    parameter int NUM_BYTE = 4,
    parameter int BYTE_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [WORD_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [WORD_W-1:0]          rsp_data,
    input  logic [NUM_EVT+NUM_BYTE-1:0] evt_strobe,
    input  logic [NUM_BYTE*BYTE_W-1:0] evt_bytes,
    output logic                       sw_rst,
    output logic                       wd_enable,
    output logic                       wd_force_fail,
    output logic                       dma_reset
);
    localparam int NUM_CNT = NUM_EVT + NUM_BYTE;
    localparam int IDX_W   = ADDR_W - 1;
    localparam int NUM_MAP = NUM_CNT + 1;

    initial begin
        assert (NUM_MAP <= (1 << IDX_W)) else $error("address space too small for bank");
    end

    logic [IDX_W-1:0] idx;
    half_e            half;
    logic             wr_hi, wr_lo, rd_req, commit_ok;
    logic             mapped, is_cnt;
    logic [WORD_W-1:0] stage_q, snap_q;
    logic [WIDE_W-1:0] cnt_val [NUM_CNT];
    logic [BYTE_W-1:0] inc_arr [NUM_CNT];
    logic [NUM_CNT-1:0] load_vec;
    logic [WIDE_W-1:0] rd_wide;
    logic [WORD_W-1:0] rd_word;
    cfg_t              cfg;

    assign idx       = req_addr[ADDR_W-1:1];
    assign half      = half_e'(req_addr[0]);
    assign wr_hi     = req_valid && req_write && (half == HALF_HI);
    assign wr_lo     = req_valid && req_write && (half == HALF_LO);
    assign rd_req    = req_valid && !req_write;
    assign commit_ok = wr_lo && !sw_rst;
    assign mapped    = (int'(idx) < NUM_MAP);
    assign is_cnt    = mapped && (idx != '0);

    wrb_stage_snap #(.W(WORD_W)) u_stage_snap (
        .clk      (clk),
        .rst      (rst),
        .ld_stage (wr_hi),
        .stage_in (req_wdata),
        .cap_snap (rd_req && (half == HALF_HI) && is_cnt),
        .snap_in  (rd_wide[WORD_W-1:0]),
        .stage_q  (stage_q),
        .snap_q   (snap_q)
    );

    wrb_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .commit (commit_ok && (idx == '0)),
        .wtop   (req_wdata[CFG_SWRST_BIT:CFG_DMARST_BIT]),
        .cfg    (cfg),
        .pulse  (sw_rst)
    );

    assign wd_enable     = cfg.wd_en;
    assign wd_force_fail = cfg.wd_fail;
    assign dma_reset     = cfg.dma_rst;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        if (i < NUM_EVT) begin : g_evt
            assign inc_arr[i] = BYTE_W'(1);
        end else begin : g_byte
            assign inc_arr[i] = evt_bytes[(i-NUM_EVT)*BYTE_W +: BYTE_W];
        end

        assign load_vec[i] = commit_ok && (idx == IDX_W'(i + 1));

        wrb_counter #(.CNT_W(WIDE_W), .INC_W(BYTE_W)) u_counter (
            .clk      (clk),
            .rst      (rst),
            .clr      (sw_rst),
            .load     (load_vec[i]),
            .load_val ({stage_q, req_wdata}),
            .inc_en   (evt_strobe[i]),
            .inc_val  (inc_arr[i]),
            .cnt      (cnt_val[i])
        );

        // R3: an odd-word commit writes staged upper half and new lower half together
        assert_commit_value_R3: assert property (@(posedge clk) disable iff (rst)
            load_vec[i] |=> cnt_val[i] == $past({stage_q, req_wdata}));
    end

    always_comb begin
        rd_wide = '0;
        if (idx == '0) begin
            rd_wide = cfg_to_wide(cfg);
        end else begin
            for (int k = 0; k < NUM_CNT; k++) begin
                if (idx == IDX_W'(k + 1)) rd_wide = cnt_val[k];
            end
        end
    end

    always_comb begin
        if (half == HALF_HI)  rd_word = rd_wide[WIDE_W-1:WORD_W];
        else if (is_cnt)      rd_word = snap_q;
        else                  rd_word = rd_wide[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) rsp_data <= rd_word;
        end
    end

    // R11: each read gets one response the next cycle, writes get none
    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid);
    assert_no_rsp_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rsp_valid);
    // R10: unmapped indices read back as zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !mapped) |=> rsp_data == '0);
    // R7: the software-reset bit never reads back as set
    assert_swrst_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && idx == '0 && half == HALF_LO) |=> !rsp_data[CFG_SWRST_BIT]);
endmodule

// File: tb/wide_reg_bank_bench.sv
module wide_reg_bank_bench;
    localparam int NC = 7;
    localparam int NE = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [4:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [6:0]  evt_strobe;
    logic [63:0] evt_bytes;
    logic        sw_rst, wd_enable, wd_force_fail, dma_reset;

    wide_reg_bank u_wide_reg_bank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .evt_strobe(evt_strobe), .evt_bytes(evt_bytes),
        .sw_rst(sw_rst), .wd_enable(wd_enable), .wd_force_fail(wd_force_fail),
        .dma_reset(dma_reset)
    );

    always #4 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R12";

    logic [63:0] mcnt [NC];
    logic [2:0]  mcfg;
    logic [31:0] mstage, msnap;
    logic        mpulse;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mwide(input int idx);
        if (idx == 0) return {32'h0, 1'b0, mcfg, 28'h0};
        if (idx >= 1 && idx <= NC) return mcnt[idx-1];
        return 64'h0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NC; i++) mcnt[i] = '0;
        mcfg = '0; mstage = '0; msnap = '0; mpulse = 0;
    endtask

    task automatic cyc(input logic v, input logic w, input logic [4:0] a,
                       input logic [31:0] d, input logic [6:0] s, input logic [63:0] b);
        int          idx;
        logic        hi, ev, commit, npulse;
        logic [31:0] ed;
        logic [63:0] wide;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        evt_strobe = s; evt_bytes = b;
        @(posedge clk);
        idx  = int'(a[4:1]);
        hi   = (a[0] == 1'b0);
        wide = mwide(idx);
        ev   = v && !w;
        ed   = '0;
        if (ev) begin
            if (hi) ed = wide[63:32];
            else if (idx >= 1 && idx <= NC) ed = msnap;
            else ed = wide[31:0];
            if (hi && idx >= 1 && idx <= NC) msnap = wide[31:0];
        end
        commit = v && w && !hi && !mpulse;
        npulse = commit && idx == 0 && d[31];
        for (int i = 0; i < NC; i++) begin
            if (mpulse) mcnt[i] = '0;
            else if (commit && idx == i + 1) mcnt[i] = {mstage, d};
            else if (s[i]) mcnt[i] = mcnt[i] + ((i < NE) ? 64'd1 : 64'(b[(i-NE)*16 +: 16]));
        end
        if (mpulse) mcfg = '0;
        else if (commit && idx == 0) mcfg = d[30:28];
        if (v && w && hi) mstage = d;
        mpulse = npulse;
        @(negedge clk);
        chk({cur_req, "/R11 rsp_valid"}, 64'(rsp_valid), 64'(ev));
        if (ev) chk({cur_req, " rsp_data"}, 64'(rsp_data), 64'(ed));
        chk("R8 sw_rst", 64'(sw_rst), 64'(mpulse));
        chk("R7 cfg fields", 64'({wd_enable, wd_force_fail, dma_reset}), 64'(mcfg));
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask
    task automatic wr(input int idx, input logic hi, input logic [31:0] d);
        cyc(1, 1, {4'(idx), ~hi}, d, 0, 0);
    endtask
    task automatic rd(input int idx, input logic hi);
        cyc(1, 0, {4'(idx), ~hi}, 0, 0, 0);
    endtask
    task automatic wr64(input int idx, input logic [63:0] v);
        wr(idx, 1, v[63:32]); wr(idx, 0, v[31:0]);
    endtask
    task automatic rd64(input int idx);
        rd(idx, 1); rd(idx, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        evt_strobe = 0; evt_bytes = 0;
        rst = 1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R12: reset state at the ports and through reads
        cur_req = "R12";
        chk("R12 rsp_valid", 64'(rsp_valid), 0);
        chk("R12 sw_rst", 64'(sw_rst), 0);
        for (int i = 0; i < 8; i++) rd64(i);

        // R4: odd write with stage still at reset value
        cur_req = "R4";
        wr(2, 0, 32'hDEAD_BEEF); rd64(2);
        // R2: even-word write alone changes nothing
        cur_req = "R2";
        wr(5, 1, 32'h1234_5678); rd64(5);
        // R3: commit uses stage, stage retained for a second commit
        cur_req = "R3";
        wr(5, 0, 32'h0000_0042); rd64(5);
        wr(6, 0, 32'h0000_0007); rd64(6);
        // R3: commit beats a strobe in the same cycle
        cyc(1, 1, {4'd1, 1'b1}, 32'h55, 7'h01, 0); rd64(1);
        // R6: wrap at 2^64 and byte accumulation
        cur_req = "R6";
        wr64(3, 64'hFFFF_FFFF_FFFF_FFFF);
        cyc(0, 0, 0, 0, 7'h04, 0); rd64(3);
        wr64(4, 64'h0000_0000_FFFF_FFF0);
        cyc(0, 0, 0, 0, 7'h08, 64'h0000_0000_0000_0020); rd64(4);
        cyc(0, 0, 0, 0, 7'h7F, 64'h0004_0003_0002_0001);
        for (int i = 1; i < 8; i++) rd64(i);
        // R5: counter moves between the two half reads
        cur_req = "R5";
        wr64(7, 64'h0000_0001_FFFF_FFFF);
        rd(7, 1);
        cyc(0, 0, 0, 0, 7'h40, 64'h0010_0000_0000_0000);
        rd(7, 0); rd64(7);
        // R7: configuration fields and zero bits
        cur_req = "R7";
        wr64(0, 64'hFFFF_FFFF_7FFF_FFFF); rd64(0);
        wr64(0, 64'h0000_0000_2000_0000); rd64(0);
        // R8, R9: software reset pulse clears everything, commit in pulse cycle dropped
        cur_req = "R9";
        wr64(0, 64'h0000_0000_D000_0000);
        wr(2, 0, 32'h0000_0099);
        idle(); rd64(0); rd64(1); rd64(2); rd64(7);
        wr(0, 0, 32'h8000_0000); idle(); idle();
        // R10: unmapped indices
        cur_req = "R10";
        wr64(9, 64'hAAAA_BBBB_CCCC_DDDD); rd64(9); rd64(15); wr(12, 0, 32'h1); rd64(1);

        // R1: random traffic across the whole map
        cur_req = "R1";
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d;
            logic [4:0]  a;
            a = 5'($urandom);
            d = $urandom;
            if (a[4:1] == 0 && ($urandom % 10) != 0) d[31] = 1'b0;
            cyc(($urandom % 4) != 0, ($urandom % 3) == 0, a, d,
                7'($urandom), {$urandom, $urandom});
        end
        for (int i = 0; i < 8; i++) rd64(i);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule